// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block decides whether a single-word relative branch is taken and supplies the next program counter. It takes a 3-bit condition selector, a 10-bit signed word offset and the four arithmetic flags: negative, zero, carry and overflow. When the condition holds, the next program counter is the current one plus twice the sign-extended offset. When it does not hold, the next program counter is the fall-through address.

The program counter input is expected to already point past the jump word. Every result is registered, so `taken_o`, `next_pc_o` and `flags_o` show the inputs that were sampled at the previous rising clock edge. The flags pass through the block unchanged, so the sequencer can write them back without any special case for a jump.

Top module: `jru_top`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it, the registered outputs are zero: `taken_o`=0, `next_pc_o`=0 and `flags_o`=0.
- R2: Each output reflects the inputs that were sampled at the preceding rising clock edge. The latency is exactly one cycle.
- R3: Selector 3'b000 is taken when Z=0. Selector 3'b001 is taken when Z=1.
- R4: Selector 3'b010 is taken when C=0 (unsigned lower). Selector 3'b011 is taken when C=1 (unsigned higher or same).
- R5: Selector 3'b100 is taken when N=1, whatever the other flags are.
- R6: Selector 3'b101 is taken when N XOR V = 0 (signed greater or equal). Selector 3'b110 is taken when N XOR V = 1 (signed less than).
- R7: Selector 3'b111 is always taken, whatever the flags are.
- R8: When the jump is taken, `next_pc_o` = (pc with bit 0 cleared) + 2 × sign-extended offset, modulo 2^16. Offset bit 9 is the sign bit.
- R9: When the jump is not taken, `next_pc_o` equals `pc_i` with bit 0 cleared. Bit 0 of `next_pc_o` is always 0.
- R10: The offset extremes 10'h200 (−512 words, −1024 bytes) and 10'h1FF (+511 words, +1022 bytes) reach their full span. The address wraps across 16'hFFFF/16'h0000 in both directions.
- R11: `flags_o` = {N,Z,C,V} (bit 3 = N, bit 0 = V) equals the sampled flag inputs, whether or not the jump is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 16 | Program counter, already past the jump word |
| cond_i | input | 3 | Condition selector |
| offset_i | input | 10 | Signed word offset |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| taken_o | output | 1 | Jump taken, registered |
| next_pc_o | output | 16 | Next program counter, registered |
| flags_o | output | 4 | Flags passed through unchanged {N,Z,C,V}, registered |

## Verification
The bench builds the block with its default parameters: a 16-bit program counter and a 10-bit offset. With these widths both offset extremes can be driven directly, and the wrap of a 16-bit address past 16'hFFFF and below 16'h0000 can be reached from a few chosen program counter values. Random selector and flag mixes cover all sixteen flag combinations under each of the eight conditions. Odd program counter values test that bit 0 is cleared on both the taken and the not-taken path.

// File: rtl/jru_pkg.sv
`timescale 1ns/1ps
// Shared types for the relative jump unit: the condition selector encoding
// and the packed flag group. Assumes a 3-bit selector with eight conditions.
package jru_pkg;
    typedef enum logic [2:0] {
        CC_NZ     = 3'd0,
        CC_Z      = 3'd1,
        CC_NC     = 3'd2,
        CC_C      = 3'd3,
        CC_NEG    = 3'd4,
        CC_GE     = 3'd5,
        CC_LT     = 3'd6,
        CC_ALWAYS = 3'd7
    } cc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/jru_cond_eval.sv
`timescale 1ns/1ps
// Condition evaluator: decides from the selector and the flags whether the
// jump is taken. Purely combinational; assumes the flags are valid as given.
module jru_cond_eval
    import jru_pkg::*;
(
    input  cc_e    cc,
    input  flags_t f,
    output logic   take
);
    logic signed_lt;

    // Signed less-than: negative and overflow disagree.
    always_comb signed_lt = f.n ^ f.v;

    // Select the flag test for the chosen condition.
    always_comb begin
        case (cc)
            CC_NZ:     take = ~f.z;
            CC_Z:      take =  f.z;
            CC_NC:     take = ~f.c;
            CC_C:      take =  f.c;
            CC_NEG:    take =  f.n;
            CC_GE:     take = ~signed_lt;
            CC_LT:     take =  signed_lt;
            default:   take = 1'b1;
        endcase
    end
endmodule

// File: rtl/jru_target.sv
`timescale 1ns/1ps
// Target calculator: forms the word-aligned fall-through address and the
// branch target pc + 2*sext(offset), wrapping modulo 2^PC_W.
// Assumes OFS_W < PC_W.
module jru_target #(
    parameter int PC_W  = 16,
    parameter int OFS_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    output logic [PC_W-1:0]  fall,
    output logic [PC_W-1:0]  target
);
    localparam int EXT_W = PC_W - OFS_W - 1;
    localparam logic [PC_W-1:0] ALIGN_MASK = {{(PC_W-1){1'b1}}, 1'b0};

    logic [PC_W-1:0] scaled;

    // Word-align the incoming program counter.
    always_comb fall = pc & ALIGN_MASK;

    // Sign-extend the offset and double it, both in one concatenation.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb scaled = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
        end else begin : g_noext
            always_comb scaled = {ofs[PC_W-2:0], 1'b0};
        end
    endgenerate

    // Add the byte displacement, wrapping at the address width.
    always_comb target = fall + scaled;
endmodule

// File: rtl/jru_top.sv
`timescale 1ns/1ps
// Conditional relative jump unit: evaluates the condition, picks the branch
// target or the fall-through address, and registers the result together with
// the unchanged flags. Synchronous active-low reset clears every output.
module jru_top
    import jru_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      pc_i,
    input  logic [2:0]       cond_i,
    input  logic [9:0]       offset_i,
    input  logic             flag_n_i,
    input  logic             flag_z_i,
    input  logic             flag_c_i,
    input  logic             flag_v_i,
    output logic             taken_o,
    output logic [15:0]      next_pc_o,
    output logic [3:0]       flags_o
);
    flags_t          flags_in;
    logic            take;
    logic [PC_W-1:0] fall;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] next_pc_d;

    // Gather the individual flag pins into the packed group.
    always_comb flags_in = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

    jru_cond_eval u_cond (
        .cc   (cc_e'(cond_i)),
        .f    (flags_in),
        .take (take)
    );

    jru_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
        .pc     (pc_i),
        .ofs    (offset_i),
        .fall   (fall),
        .target (target)
    );

    // Choose between the branch target and the fall-through address.
    always_comb next_pc_d = take ? target : fall;

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            flags_o   <= '0;
        end else begin
            taken_o   <= take;
            next_pc_o <= next_pc_d;
            flags_o   <= flags_in;
        end
    end
endmodule

// File: rtl/jru_chk.sv
`timescale 1ns/1ps
// Checker for jru_top: relates the registered outputs to the inputs of the
// previous cycle. A primed flag holds the checks off until one full cycle
// after reset has been released.
module jru_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] pc_i,
    input logic [2:0]  cond_i,
    input logic [9:0]  offset_i,
    input logic        flag_n_i,
    input logic        flag_z_i,
    input logic        flag_c_i,
    input logic        flag_v_i,
    input logic        taken_o,
    input logic [15:0] next_pc_o,
    input logic [3:0]  flags_o
);
    logic primed;

    // Marks that one cycle of history has been gathered since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (taken_o == 1'b0 && next_pc_o == 16'h0 && flags_o == 4'h0));

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> flags_o == $past({flag_n_i, flag_z_i, flag_c_i, flag_v_i}));

    p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_i) == 3'd7) |-> taken_o);

    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_i) == 3'd1) |-> taken_o == $past(flag_z_i));

    p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_i) == 3'd3) |-> taken_o == $past(flag_c_i));

    p_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_i) == 3'd4) |-> taken_o == $past(flag_n_i));

    p_lt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(cond_i) == 3'd6) |-> taken_o == ($past(flag_n_i) != $past(flag_v_i)));

    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc_o[0] == 1'b0);

    p_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken_o) |-> next_pc_o[15:1] == $past(pc_i[15:1]));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(pc_i) == 16'h0 && $past(cond_i) != 3'd7 && !taken_o)
        |-> next_pc_o == 16'h0);
endmodule

bind jru_top jru_chk u_jru_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_i      (pc_i),
    .cond_i    (cond_i),
    .offset_i  (offset_i),
    .flag_n_i  (flag_n_i),
    .flag_z_i  (flag_z_i),
    .flag_c_i  (flag_c_i),
    .flag_v_i  (flag_v_i),
    .taken_o   (taken_o),
    .next_pc_o (next_pc_o),
    .flags_o   (flags_o)
);

// File: tb/test_jru_top.sv
`timescale 1ns/1ps
// Bench for jru_top: directed corner cases followed by seeded random vectors,
// each compared against a reference model computed by bench functions.
module test_jru_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = '0;
    logic [2:0]  cond_i = '0;
    logic [9:0]  offset_i = '0;
    logic        flag_n_i = 1'b0;
    logic        flag_z_i = 1'b0;
    logic        flag_c_i = 1'b0;
    logic        flag_v_i = 1'b0;
    logic        taken_o;
    logic [15:0] next_pc_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    jru_top i_jru_top (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .cond_i(cond_i),
        .offset_i(offset_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
        .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .flags_o(flags_o)
    );

    function automatic bit ref_take(input logic [2:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !cy;
            3'd3: return cy;
            3'd4: return n;
            3'd5: return (n == v);
            3'd6: return (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] ref_pc(input logic [15:0] pc, input logic [2:0] c,
                                           input logic [9:0] o, input logic [3:0] f);
        logic [15:0] base;
        int          disp;
        base = {pc[15:1], 1'b0};
        disp = (o[9] ? int'(o) - 1024 : int'(o)) * 2;
        if (ref_take(c, f)) return 16'(int'(base) + disp);
        return base;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one vector, wait one edge, check all three outputs.
    task automatic run(input string req, input logic [15:0] pc, input logic [2:0] c,
                       input logic [9:0] o, input logic [3:0] f);
        @(negedge clk);
        pc_i = pc; cond_i = c; offset_i = o;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = f;
        @(posedge clk);
        #1;
        check({req, " taken"}, 32'(taken_o), 32'(ref_take(c, f)));
        check({req, " pc"}, 32'(next_pc_o), 32'(ref_pc(pc, c, o, f)));
        check({req, " flags R11"}, 32'(flags_o), 32'(f));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        pc_i = 16'h1234; cond_i = 3'd7; flag_n_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 taken", 32'(taken_o), 32'd0);
        check("R1 pc", 32'(next_pc_o), 32'd0);
        check("R1 flags", 32'(flags_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 zero tests
        run("R3 nz z0", 16'h1000, 3'd0, 10'h004, 4'b0000);
        run("R3 nz z1", 16'h1000, 3'd0, 10'h004, 4'b0100);
        run("R3 z z1",  16'h1000, 3'd1, 10'h3FC, 4'b0100);
        run("R3 z z0",  16'h1000, 3'd1, 10'h3FC, 4'b1011);
        // R4 carry tests
        run("R4 nc c0", 16'h2000, 3'd2, 10'h010, 4'b0000);
        run("R4 nc c1", 16'h2000, 3'd2, 10'h010, 4'b0010);
        run("R4 c c1",  16'h2000, 3'd3, 10'h010, 4'b0010);
        run("R4 c c0",  16'h2000, 3'd3, 10'h010, 4'b1101);
        // R5 negative
        run("R5 n1", 16'h3000, 3'd4, 10'h001, 4'b1000);
        run("R5 n0", 16'h3000, 3'd4, 10'h001, 4'b0111);
        // R6 signed comparisons
        run("R6 ge nv11", 16'h4000, 3'd5, 10'h020, 4'b1001);
        run("R6 ge nv10", 16'h4000, 3'd5, 10'h020, 4'b1000);
        run("R6 lt nv01", 16'h4000, 3'd6, 10'h020, 4'b0001);
        run("R6 lt nv00", 16'h4000, 3'd6, 10'h020, 4'b0000);
        // R7 always
        run("R7 f0", 16'h5000, 3'd7, 10'h100, 4'b0000);
        run("R7 f1", 16'h5000, 3'd7, 10'h100, 4'b1111);
        // R8/R10 extremes and wrap
        run("R10 min", 16'h8000, 3'd7, 10'h200, 4'b0000);
        run("R10 max", 16'h8000, 3'd7, 10'h1FF, 4'b0000);
        run("R10 wrap up", 16'hFFFE, 3'd7, 10'h1FF, 4'b0000);
        run("R10 wrap dn", 16'h0002, 3'd7, 10'h200, 4'b0000);
        run("R8 zero ofs", 16'h0AB0, 3'd7, 10'h000, 4'b0000);
        // R9 odd pc on both paths
        run("R9 odd taken", 16'h1235, 3'd7, 10'h002, 4'b0000);
        run("R9 odd fall",  16'hFFFF, 3'd1, 10'h002, 4'b0000);
        // R2 back-to-back changes, each checked one edge later
        run("R2 seq a", 16'h0100, 3'd0, 10'h3FF, 4'b0000);
        run("R2 seq b", 16'h0200, 3'd0, 10'h3FF, 4'b0100);

        for (int i = 0; i < 2000; i++) begin
            run("R8 rand", 16'($urandom), 3'($urandom), 10'($urandom), 4'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule